// File: doc/BRIEF.md
# Reduction Line Combiner for a Node Directory

This block sits in the directory controller of one node of a shared-memory machine and handles whole cache lines that belong to reduction arrays. Reduction data is reached through a shadow alias: the same line address with its most significant bit set. When the local cache misses on such an alias, the block answers by itself with a line filled with the identity value of the configured operator. When the local cache writes back such a line, the block forwards it toward the home node under its real address.

At the home node, a reduction write-back coming from any node is not simply written over memory. The block reads the current line and its directory word from a line-wide memory and recalls a dirty copy held by an ordinary cache, if there is one. It then sends invalidations to the remaining ordinary sharers and folds the incoming line into the stored one, one element per cycle. It writes the result back with an empty directory word. The operator (wrapping add, signed maximum or signed minimum on 32-bit elements) is chosen once through a small configuration input and applies to every element of a line.

The home path is a state machine. IDLE accepts a write-back and goes to READ, which issues the memory read. CAPTURE takes the line and directory word, then goes to RECALL if the dirty flag is set or to INVAL if it is not. RECALL waits for the recalled line and then goes to INVAL. INVAL pulses the invalidation mask and goes to COMBINE. COMBINE spends one cycle per element and goes to WRITE after the last one. WRITE stores the line and returns to IDLE.

Top module: `redn_line_combiner`

## Requirements
- R1: A local read (loc_is_wb=0) whose address has its top bit set gets, on the cycle after it is presented, loc_rsp_valid with every 32-bit element equal to the identity of the operator: 0 for add (code 0), 0x80000000 for max (code 1), 0x7FFFFFFF for min (code 2).
- R2: A local read or write-back whose address has its top bit clear produces neither loc_rsp_valid nor fwd_valid.
- R3: A local write-back to a shadow address produces fwd_valid on the next cycle, with fwd_addr equal to the address with its top bit cleared and fwd_line equal to the written line.
- R4: A write-back accepted on rem_valid/rem_ready leaves the memory line at the address with its top bit cleared equal to op(stored, incoming) for each element. Add wraps modulo 2^32; max and min compare as signed values.
- R5: Elements of an incoming line that hold the operator's identity leave the matching stored elements unchanged.
- R6: The operator is add after reset. A configuration write with code 3 leaves the active operator unchanged.
- R7: The directory word is {dirty[6], owner[5:4], sharers[3:0]}. When dirty is set, recall_valid is raised with recall_node equal to owner, and the line returned on recall_ack replaces the stored line as the base of the merge.
- R8: Exactly one inval_valid pulse is raised per write-back whose sharer bits, minus the owner bit when dirty, are non-zero, and inval_mask carries those bits. No pulse is raised when that set is empty.
- R9: The directory word written with the merged line is zero, so a later write-back to that line causes no recall and no invalidation.
- R10: rem_ready is low from the cycle after a write-back is accepted until its memory write. A second write-back to the same line is therefore merged onto the result of the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | Operator code: 0 add, 1 max, 2 min, 3 ignored |
| loc_valid | input | 1 | Local cache request valid |
| loc_is_wb | input | 1 | 1 for write-back, 0 for read miss |
| loc_addr | input | ADDR_W | Local request line address |
| loc_line | input | ELEMS*ELEM_W | Local write-back payload |
| loc_rsp_valid | output | 1 | Identity-line reply valid |
| loc_rsp_line | output | ELEMS*ELEM_W | Identity-line reply |
| fwd_valid | output | 1 | Forwarded write-back valid |
| fwd_addr | output | ADDR_W | Home (real) address of the forwarded line |
| fwd_line | output | ELEMS*ELEM_W | Forwarded payload |
| rem_valid | input | 1 | Incoming reduction write-back valid |
| rem_ready | output | 1 | Home path can accept a write-back |
| rem_addr | input | ADDR_W | Incoming write-back address (shadow or real) |
| rem_line | input | ELEMS*ELEM_W | Incoming partial-result line |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory line address |
| mem_wline | output | ELEMS*ELEM_W | Line to write |
| mem_wdir | output | NODES+clog2(NODES)+1 | Directory word to write |
| mem_rline | input | ELEMS*ELEM_W | Line read, valid one cycle after the read |
| mem_rdir | input | NODES+clog2(NODES)+1 | Directory word read |
| recall_valid | output | 1 | Recall request to the dirty owner |
| recall_node | output | clog2(NODES) | Node to recall from |
| recall_ack | input | 1 | Recalled line present |
| recall_line | input | ELEMS*ELEM_W | Recalled line |
| inval_valid | output | 1 | Invalidation pulse |
| inval_mask | output | NODES | Nodes to invalidate |

## Verification
The hardest case to reach from the ports is a write-back to a line that is still held dirty by an ordinary cache and shared by other nodes, followed at once by a second write-back to the same line. In that case the recall, the invalidation mask, the base of the merge and the hold-off all interact. The bench presets directory words in its memory model with random dirty owners and sharer sets, and answers recalls with a line different from memory. A directed sequence then presents a second write-back while the first is still merging. Random lines mix identity elements with values near the signed limits, so that wrapping and signed comparison are exercised under all three operators.

// File: rtl/redn_pkg.sv
package redn_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_MAX  = 2'd1,
        OP_MIN  = 2'd2,
        OP_RSVD = 2'd3
    } redn_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CAPTURE,
        ST_RECALL,
        ST_INVAL,
        ST_COMBINE,
        ST_WRITE
    } home_st_e;

endpackage

// File: rtl/redn_shadow_xlate.sv
module redn_shadow_xlate #(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_in,
    output logic              is_shadow,
    output logic [ADDR_W-1:0] home_addr
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        is_shadow      = addr_in[TOP];
        home_addr      = addr_in;
        home_addr[TOP] = 1'b0;
    end
endmodule

// File: rtl/redn_identity_line.sv
module redn_identity_line
    import redn_pkg::*;
#(
    parameter int ELEM_W = 32,
    parameter int ELEMS  = 8
) (
    input  redn_op_e                  op,
    output logic [ELEMS*ELEM_W-1:0]   line
);
    logic [ELEM_W-1:0] ident;

    always_comb begin
        unique case (op)
            OP_MAX:  ident = {1'b1, {(ELEM_W-1){1'b0}}};
            OP_MIN:  ident = {1'b0, {(ELEM_W-1){1'b1}}};
            default: ident = '0;
        endcase
    end

    for (genvar g = 0; g < ELEMS; g++) begin : g_fill
        assign line[g*ELEM_W +: ELEM_W] = ident;
    end
endmodule

// File: rtl/redn_elem_alu.sv
module redn_elem_alu
    import redn_pkg::*;
#(
    parameter int ELEM_W = 32
) (
    input  redn_op_e          op,
    input  logic [ELEM_W-1:0] a,
    input  logic [ELEM_W-1:0] b,
    output logic [ELEM_W-1:0] y
);
    logic a_lt_b;

    assign a_lt_b = $signed(a) < $signed(b);

    always_comb begin
        unique case (op)
            OP_MAX:  y = a_lt_b ? b : a;
            OP_MIN:  y = a_lt_b ? a : b;
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/redn_line_combiner.sv
module redn_line_combiner
    import redn_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int ELEM_W = 32,
    parameter int ELEMS  = 8,
    parameter int NODES  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_wr,
    input  logic [1:0]                        cfg_op,
    input  logic                              loc_valid,
    input  logic                              loc_is_wb,
    input  logic [ADDR_W-1:0]                 loc_addr,
    input  logic [ELEMS*ELEM_W-1:0]           loc_line,
    output logic                              loc_rsp_valid,
    output logic [ELEMS*ELEM_W-1:0]           loc_rsp_line,
    output logic                              fwd_valid,
    output logic [ADDR_W-1:0]                 fwd_addr,
    output logic [ELEMS*ELEM_W-1:0]           fwd_line,
    input  logic                              rem_valid,
    output logic                              rem_ready,
    input  logic [ADDR_W-1:0]                 rem_addr,
    input  logic [ELEMS*ELEM_W-1:0]           rem_line,
    output logic                              mem_req,
    output logic                              mem_we,
    output logic [ADDR_W-1:0]                 mem_addr,
    output logic [ELEMS*ELEM_W-1:0]           mem_wline,
    output logic [NODES+$clog2(NODES):0]      mem_wdir,
    input  logic [ELEMS*ELEM_W-1:0]           mem_rline,
    input  logic [NODES+$clog2(NODES):0]      mem_rdir,
    output logic                              recall_valid,
    output logic [$clog2(NODES)-1:0]          recall_node,
    input  logic                              recall_ack,
    input  logic [ELEMS*ELEM_W-1:0]           recall_line,
    output logic                              inval_valid,
    output logic [NODES-1:0]                  inval_mask
);
    localparam int LINE_W = ELEMS * ELEM_W;
    localparam int OWN_W  = $clog2(NODES);
    localparam int DIR_W  = NODES + OWN_W + 1;
    localparam int IDX_W  = (ELEMS > 1) ? $clog2(ELEMS) : 1;
    localparam int DIRTY  = DIR_W - 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ELEMS - 1);

    // ---------------- configuration ----------------
    redn_op_e op_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= OP_ADD;
        end else if (cfg_wr && (redn_op_e'(cfg_op) != OP_RSVD)) begin
            op_q <= redn_op_e'(cfg_op);
        end
    end

    // ---------------- local path ----------------
    logic              loc_shadow;
    logic [ADDR_W-1:0] loc_home;
    logic [LINE_W-1:0] ident_line;

    redn_shadow_xlate #(.ADDR_W(ADDR_W)) loc_xlate_i (
        .addr_in  (loc_addr),
        .is_shadow(loc_shadow),
        .home_addr(loc_home)
    );

    redn_identity_line #(.ELEM_W(ELEM_W), .ELEMS(ELEMS)) ident_i (
        .op  (op_q),
        .line(ident_line)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_rsp_valid <= 1'b0;
            loc_rsp_line  <= '0;
            fwd_valid     <= 1'b0;
            fwd_addr      <= '0;
            fwd_line      <= '0;
        end else begin
            loc_rsp_valid <= loc_valid && !loc_is_wb && loc_shadow;
            fwd_valid     <= loc_valid && loc_is_wb && loc_shadow;
            if (loc_valid && !loc_is_wb && loc_shadow) begin
                loc_rsp_line <= ident_line;
            end
            if (loc_valid && loc_is_wb && loc_shadow) begin
                fwd_addr <= loc_home;
                fwd_line <= loc_line;
            end
        end
    end

    // ---------------- home path ----------------
    home_st_e          state_q, state_d;
    logic [ADDR_W-1:0] home_q;
    logic [LINE_W-1:0] base_q;
    logic [LINE_W-1:0] inc_q;
    logic [DIR_W-1:0]  dir_q;
    logic [IDX_W-1:0]  idx_q;
    logic              rem_shadow_unused;
    logic [ADDR_W-1:0] rem_home;
    logic [ELEM_W-1:0] alu_y;
    logic [NODES-1:0]  others;

    redn_shadow_xlate #(.ADDR_W(ADDR_W)) rem_xlate_i (
        .addr_in  (rem_addr),
        .is_shadow(rem_shadow_unused),
        .home_addr(rem_home)
    );

    redn_elem_alu #(.ELEM_W(ELEM_W)) alu_i (
        .op(op_q),
        .a (base_q[idx_q*ELEM_W +: ELEM_W]),
        .b (inc_q[idx_q*ELEM_W +: ELEM_W]),
        .y (alu_y)
    );

    always_comb begin
        others = dir_q[NODES-1:0];
        if (dir_q[DIRTY]) begin
            others[dir_q[NODES +: OWN_W]] = 1'b0;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (rem_valid) state_d = ST_READ;
            ST_READ:    state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = mem_rdir[DIRTY] ? ST_RECALL : ST_INVAL;
            ST_RECALL:  if (recall_ack) state_d = ST_INVAL;
            ST_INVAL:   state_d = ST_COMBINE;
            ST_COMBINE: if (idx_q == LAST_IDX) state_d = ST_WRITE;
            ST_WRITE:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            home_q <= '0;
            base_q <= '0;
            inc_q  <= '0;
            dir_q  <= '0;
            idx_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    idx_q <= '0;
                    if (rem_valid) begin
                        home_q <= rem_home;
                        inc_q  <= rem_line;
                    end
                end
                ST_CAPTURE: begin
                    base_q <= mem_rline;
                    dir_q  <= mem_rdir;
                end
                ST_RECALL: begin
                    if (recall_ack) base_q <= recall_line;
                end
                ST_COMBINE: begin
                    base_q[idx_q*ELEM_W +: ELEM_W] <= alu_y;
                    idx_q <= idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        rem_ready    = 1'b0;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = home_q;
        mem_wline    = base_q;
        mem_wdir     = '0;
        recall_valid = 1'b0;
        recall_node  = dir_q[NODES +: OWN_W];
        inval_valid  = 1'b0;
        inval_mask   = others;
        unique case (state_q)
            ST_IDLE:   rem_ready = 1'b1;
            ST_READ:   mem_req = 1'b1;
            ST_RECALL: recall_valid = 1'b1;
            ST_INVAL:  inval_valid = |others;
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/redn_line_combiner_chk.sv
module redn_line_combiner_chk #(
    parameter int ADDR_W = 12,
    parameter int ELEM_W = 32,
    parameter int ELEMS  = 8,
    parameter int NODES  = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         loc_valid,
    input logic                         loc_is_wb,
    input logic [ADDR_W-1:0]            loc_addr,
    input logic [ELEMS*ELEM_W-1:0]      loc_line,
    input logic                         loc_rsp_valid,
    input logic                         fwd_valid,
    input logic [ADDR_W-1:0]            fwd_addr,
    input logic [ELEMS*ELEM_W-1:0]      fwd_line,
    input logic                         rem_valid,
    input logic                         rem_ready,
    input logic                         mem_req,
    input logic                         mem_we,
    input logic [NODES+$clog2(NODES):0] mem_wdir,
    input logic                         recall_valid,
    input logic                         inval_valid
);
    // R1: a reply only follows a local shadow read
    a_r1_rsp_after_shadow_read: assert property (@(posedge clk) disable iff (!rst_n)
        loc_rsp_valid |-> $past(loc_valid && !loc_is_wb && loc_addr[ADDR_W-1]));

    // R2: no reply or forward follows a non-shadow request
    a_r2_plain_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && !loc_addr[ADDR_W-1]) |=> (!loc_rsp_valid && !fwd_valid));

    // R3: forwarded line matches the written line and carries a real address
    a_r3_fwd_payload: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (fwd_line == $past(loc_line)) && !fwd_addr[ADDR_W-1]);

    // R9: the directory word stored with a merged line is empty
    a_r9_dir_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdir == '0));

    // R10: no new write-back is taken the cycle after one is accepted
    a_r10_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_valid && rem_ready) |=> !rem_ready);

    // R10: the home path is idle only when it neither touches memory nor recalls
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rem_ready |-> (!mem_req && !recall_valid && !inval_valid));

    // R7: recall and invalidation never overlap
    a_r7_recall_then_inval: assert property (@(posedge clk) disable iff (!rst_n)
        !(recall_valid && inval_valid));
endmodule

bind redn_line_combiner redn_line_combiner_chk #(
    .ADDR_W(ADDR_W), .ELEM_W(ELEM_W), .ELEMS(ELEMS), .NODES(NODES)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .loc_valid    (loc_valid),
    .loc_is_wb    (loc_is_wb),
    .loc_addr     (loc_addr),
    .loc_line     (loc_line),
    .loc_rsp_valid(loc_rsp_valid),
    .fwd_valid    (fwd_valid),
    .fwd_addr     (fwd_addr),
    .fwd_line     (fwd_line),
    .rem_valid    (rem_valid),
    .rem_ready    (rem_ready),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_wdir     (mem_wdir),
    .recall_valid (recall_valid),
    .inval_valid  (inval_valid)
);

// File: tb/redn_line_combiner_tb.sv
module redn_line_combiner_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int ELEM_W = 32;
    localparam int ELEMS  = 8;
    localparam int NODES  = 4;
    localparam int LINE_W = ELEMS * ELEM_W;
    localparam int DIR_W  = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic              cfg_wr = 0;
    logic [1:0]        cfg_op = 0;
    logic              loc_valid = 0, loc_is_wb = 0;
    logic [ADDR_W-1:0] loc_addr = 0;
    logic [LINE_W-1:0] loc_line = 0;
    logic              loc_rsp_valid, fwd_valid;
    logic [LINE_W-1:0] loc_rsp_line, fwd_line;
    logic [ADDR_W-1:0] fwd_addr;
    logic              rem_valid = 0, rem_ready;
    logic [ADDR_W-1:0] rem_addr = 0;
    logic [LINE_W-1:0] rem_line = 0;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [LINE_W-1:0] mem_wline;
    logic [DIR_W-1:0]  mem_wdir;
    logic [LINE_W-1:0] mem_rline = 0;
    logic [DIR_W-1:0]  mem_rdir = 0;
    logic              recall_valid;
    logic [1:0]        recall_node;
    logic              recall_ack = 0;
    logic [LINE_W-1:0] recall_line = 0;
    logic              inval_valid;
    logic [NODES-1:0]  inval_mask;

    redn_line_combiner #(.ADDR_W(ADDR_W), .ELEM_W(ELEM_W), .ELEMS(ELEMS), .NODES(NODES)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_op(cfg_op),
        .loc_valid(loc_valid), .loc_is_wb(loc_is_wb), .loc_addr(loc_addr), .loc_line(loc_line),
        .loc_rsp_valid(loc_rsp_valid), .loc_rsp_line(loc_rsp_line),
        .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_line(fwd_line),
        .rem_valid(rem_valid), .rem_ready(rem_ready), .rem_addr(rem_addr), .rem_line(rem_line),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wline(mem_wline),
        .mem_wdir(mem_wdir), .mem_rline(mem_rline), .mem_rdir(mem_rdir),
        .recall_valid(recall_valid), .recall_node(recall_node),
        .recall_ack(recall_ack), .recall_line(recall_line),
        .inval_valid(inval_valid), .inval_mask(inval_mask)
    );

    // memory model: 16 lines with directory words, one-cycle read
    logic [LINE_W-1:0] mem_q [16];
    logic [DIR_W-1:0]  dir_q [16];
    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            mem_q[mem_addr[3:0]] <= mem_wline;
            dir_q[mem_addr[3:0]] <= mem_wdir;
        end else if (mem_req) begin
            mem_rline <= mem_q[mem_addr[3:0]];
            mem_rdir  <= dir_q[mem_addr[3:0]];
        end
    end

    // recall responder and invalidation monitor
    int rc_cnt = 0, inv_cnt = 0;
    logic [1:0]       rc_node_seen = 0;
    logic [NODES-1:0] inv_mask_seen = 0;
    always @(negedge clk) begin
        if (recall_valid && !recall_ack) begin
            recall_ack = 1'b1;
            rc_cnt++;
            rc_node_seen = recall_node;
        end else begin
            recall_ack = 1'b0;
        end
        if (inval_valid) begin
            inv_cnt++;
            inv_mask_seen = inval_mask;
        end
    end

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [LINE_W-1:0] act,
                       input logic [LINE_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [ELEM_W-1:0] f_ident(input int op);
        case (op)
            1:       return 32'h8000_0000;
            2:       return 32'h7FFF_FFFF;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [ELEM_W-1:0] f_op(input int op, input logic [ELEM_W-1:0] a,
                                               input logic [ELEM_W-1:0] b);
        case (op)
            1:       return ($signed(a) > $signed(b)) ? a : b;
            2:       return ($signed(a) < $signed(b)) ? a : b;
            default: return a + b;
        endcase
    endfunction

    function automatic logic [LINE_W-1:0] f_line_op(input int op, input logic [LINE_W-1:0] a,
                                                    input logic [LINE_W-1:0] b);
        logic [LINE_W-1:0] r;
        for (int i = 0; i < ELEMS; i++)
            r[i*ELEM_W +: ELEM_W] = f_op(op, a[i*ELEM_W +: ELEM_W], b[i*ELEM_W +: ELEM_W]);
        return r;
    endfunction

    function automatic logic [LINE_W-1:0] f_ident_line(input int op);
        logic [LINE_W-1:0] r;
        for (int i = 0; i < ELEMS; i++) r[i*ELEM_W +: ELEM_W] = f_ident(op);
        return r;
    endfunction

    function automatic logic [ELEM_W-1:0] f_rand_elem();
        case ($urandom % 4)
            0:       return 32'h7FFF_FFF0 + ($urandom % 32);
            1:       return 32'h8000_0000 + ($urandom % 16);
            default: return $urandom;
        endcase
    endfunction

    function automatic logic [LINE_W-1:0] f_rand_line();
        logic [LINE_W-1:0] r;
        for (int i = 0; i < ELEMS; i++) r[i*ELEM_W +: ELEM_W] = f_rand_elem();
        return r;
    endfunction

    int cur_op = 0;

    task automatic set_op(input int code);
        @(negedge clk);
        cfg_wr = 1; cfg_op = code[1:0];
        @(negedge clk);
        cfg_wr = 0;
        if (code != 3) cur_op = code;
    endtask

    task automatic loc_req(input bit wb, input logic [ADDR_W-1:0] a, input logic [LINE_W-1:0] l);
        @(negedge clk);
        loc_valid = 1; loc_is_wb = wb; loc_addr = a; loc_line = l;
        @(negedge clk);
        loc_valid = 0;
    endtask

    task automatic wb_start(input logic [ADDR_W-1:0] a, input logic [LINE_W-1:0] l);
        rem_valid = 1; rem_addr = a; rem_line = l;
        while (!rem_ready) @(negedge clk);
        @(negedge clk);
        rem_valid = 0;
    endtask

    task automatic wb_wait();
        while (!rem_ready) @(negedge clk);
    endtask

    // one full write-back with directory preset and all checks
    task automatic home_wb(input int idx, input bit shadow, input logic [LINE_W-1:0] stored,
                           input logic [DIR_W-1:0] dir, input logic [LINE_W-1:0] inc,
                           input logic [LINE_W-1:0] rline);
        logic [LINE_W-1:0] base, expv;
        logic [NODES-1:0]  oth;
        int rc0, inv0;
        @(negedge clk);
        mem_q[idx] = stored; dir_q[idx] = dir; recall_line = rline;
        base = dir[6] ? rline : stored;
        expv = f_line_op(cur_op, base, inc);
        oth = dir[3:0];
        if (dir[6]) oth[dir[5:4]] = 1'b0;
        rc0 = rc_cnt; inv0 = inv_cnt;
        wb_start({shadow, 7'd0, idx[3:0]}, inc);
        wb_wait();
        chk(mem_q[idx] == expv, "R4 merged line", mem_q[idx], expv);
        chk(dir_q[idx] == 0, "R9 directory cleared", LINE_W'(dir_q[idx]), '0);
        chk((rc_cnt - rc0) == (dir[6] ? 1 : 0), "R7 recall count",
            LINE_W'(rc_cnt - rc0), LINE_W'(dir[6]));
        if (dir[6])
            chk(rc_node_seen == dir[5:4], "R7 recall node", LINE_W'(rc_node_seen), LINE_W'(dir[5:4]));
        chk((inv_cnt - inv0) == ((oth != 0) ? 1 : 0), "R8 inval count",
            LINE_W'(inv_cnt - inv0), LINE_W'(oth != 0));
        if (oth != 0)
            chk(inv_mask_seen == oth, "R8 inval mask", LINE_W'(inv_mask_seen), LINE_W'(oth));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [LINE_W-1:0] l1, l2, st, expv, inc;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 16; i++) begin mem_q[i] = '0; dir_q[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!loc_rsp_valid && !fwd_valid && rem_ready && !recall_valid && !inval_valid,
            "reset state", {loc_rsp_valid, fwd_valid, rem_ready, recall_valid, inval_valid},
            LINE_W'(5'b00100));

        // R1/R6: default operator is add
        loc_req(0, 12'h805, '0);
        chk(loc_rsp_valid && loc_rsp_line == f_ident_line(0), "R1 R6 add identity",
            loc_rsp_line, f_ident_line(0));
        set_op(1);
        loc_req(0, 12'h806, '0);
        chk(loc_rsp_valid && loc_rsp_line == f_ident_line(1), "R1 max identity",
            loc_rsp_line, f_ident_line(1));
        set_op(2);
        loc_req(0, 12'h807, '0);
        chk(loc_rsp_valid && loc_rsp_line == f_ident_line(2), "R1 min identity",
            loc_rsp_line, f_ident_line(2));
        set_op(3);
        loc_req(0, 12'h808, '0);
        chk(loc_rsp_valid && loc_rsp_line == f_ident_line(2), "R6 code 3 ignored",
            loc_rsp_line, f_ident_line(2));

        // R2: non-shadow requests
        loc_req(0, 12'h005, '0);
        chk(!loc_rsp_valid && !fwd_valid, "R2 plain read ignored",
            LINE_W'({loc_rsp_valid, fwd_valid}), '0);
        loc_req(1, 12'h006, f_rand_line());
        chk(!loc_rsp_valid && !fwd_valid, "R2 plain write-back ignored",
            LINE_W'({loc_rsp_valid, fwd_valid}), '0);

        // R3: forwarding
        l1 = f_rand_line();
        loc_req(1, 12'hA3C, l1);
        chk(fwd_valid && fwd_addr == 12'h23C, "R3 forward address",
            LINE_W'(fwd_addr), LINE_W'(12'h23C));
        chk(fwd_line == l1, "R3 forward line", fwd_line, l1);

        // R5: identity lines leave memory unchanged under each operator
        for (int op = 0; op < 3; op++) begin
            set_op(op);
            st = f_rand_line();
            home_wb(op + 1, 1'b1, st, '0, f_ident_line(op), '0);
            chk(mem_q[op + 1] == st, "R5 identity no change", mem_q[op + 1], st);
        end

        // R7/R8: dirty owner 2, sharers 1,2,3 -> recall node 2, invalidate 1 and 3
        set_op(0);
        home_wb(4, 1'b1, f_rand_line(), 7'b1_10_1110, f_rand_line(), f_rand_line());
        // R9: following write-back to same line, no recall or invalidation
        home_wb(4, 1'b0, mem_q[4], dir_q[4], f_rand_line(), '0);
        // R8: only the owner shares -> no invalidation pulse
        home_wb(5, 1'b1, f_rand_line(), 7'b1_01_0010, f_rand_line(), f_rand_line());

        // R10: back-to-back write-backs to one line
        set_op(1);
        st = f_rand_line(); l1 = f_rand_line(); l2 = f_rand_line();
        @(negedge clk);
        mem_q[6] = st; dir_q[6] = '0;
        wb_start(12'h806, l1);
        rem_valid = 1; rem_addr = 12'h806; rem_line = l2;
        chk(!rem_ready, "R10 ready low while busy", LINE_W'(rem_ready), '0);
        @(negedge clk);
        chk(!rem_ready, "R10 ready still low", LINE_W'(rem_ready), '0);
        wb_start(12'h806, l2);
        wb_wait();
        expv = f_line_op(1, f_line_op(1, st, l1), l2);
        chk(mem_q[6] == expv, "R10 second merge on first result", mem_q[6], expv);

        // random mix
        for (int n = 0; n < 60; n++) begin
            logic [DIR_W-1:0] d;
            int idx;
            if ($urandom % 5 == 0) set_op($urandom % 4);
            idx = $urandom % 16;
            inc = f_rand_line();
            for (int e = 0; e < ELEMS; e++)
                if ($urandom % 2) inc[e*ELEM_W +: ELEM_W] = f_ident(cur_op);
            d = ($urandom % 3 == 0) ? DIR_W'($urandom) | 7'h40 : DIR_W'($urandom % 16);
            home_wb(idx, $urandom % 2, f_rand_line(), d, inc, f_rand_line());
            if ($urandom % 4 == 0) begin
                loc_req(0, 12'h800 | 12'($urandom % 256), '0);
                chk(loc_rsp_line == f_ident_line(cur_op), "R1 random identity",
                    loc_rsp_line, f_ident_line(cur_op));
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule